// File: doc/BRIEF.md
# Level-Sensitive Interrupt Detector and Vectoring Sequencer

This block turns four asynchronous, active-low interrupt request pins into serviced interrupts. Each pin goes through a two-stage synchronizer and is then sampled once per clock. A sample that finds the request asserted sets a pending flag for that source. The sample that follows a detection is ignored, so a request pulse held across one or two sampling edges is counted once. A pulse held across three edges is counted twice. All logic runs on the rising edge of `clk`, and that edge stands for the processor's sampling edge.

When the processor signals an instruction-fetch boundary, the global enable is set and at least one pending, enabled flag exists, the sequencer accepts the lowest-numbered candidate. The response then runs in three steps:

1. It issues a one-cycle vector-table read at `VEC_BASE + n` and clears the winner's flag.
2. It captures the returned vector word on the following cycle.
3. It issues the fetch of the first service-routine instruction at that vector, together with an acknowledge that carries the source number.

The memory must return read data on the cycle after the read strobe.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pend` is 0, `mem_rd` is 0 and `ack` is 0.
- R2: If `irq_n[n]` is driven low before a clock edge k and held, `pend[n]` is first seen set after edge k+2: two synchronizer stages plus the detection register.
- R3: The sample taken on the edge after a detection is ignored. A low pulse covering exactly 1 or 2 edges produces exactly one service of that source. A pulse covering exactly 3 edges produces exactly two services.
- R4: A vector read is issued only in the cycle after an edge at which `fetch_bnd` was 1. While `fetch_bnd` is 0, pending flags stay set and `mem_rd` stays 0.
- R5: With `gie` = 0, no read is issued, but detections still set `pend`. Pending requests are serviced once `gie` returns to 1.
- R6: A source whose `int_en` bit is 0 is never accepted, and its flag stays set. Once the bit is set to 1, the source is serviced.
- R7: When several flags are pending and enabled at an acceptance, the lowest-numbered source is serviced first.
- R8: The vector read is a single cycle with `mem_rd` = 1, `ack` = 0 and `mem_addr` = `VEC_BASE` + n. The winner's `pend` bit is seen cleared after the edge that ends this cycle, unless the same edge produces a new detection, in which case the bit stays set.
- R9: Two cycles after the vector read, `mem_rd` = 1 and `ack` = 1 for one cycle. In that cycle `ack_id` = n and `mem_addr` equals the low `ADDR_W` bits of the word that was on `mem_rdata` in the cycle after the vector read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and sequencing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | NSRC | Asynchronous active-low interrupt requests |
| gie | input | 1 | Global enable for the response sequence |
| int_en | input | NSRC | Per-source enable, 1 = may be accepted |
| fetch_bnd | input | 1 | Instruction-fetch boundary strobe |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | ADDR_W | Vector-table or service-routine address |
| mem_rd | output | 1 | Read strobe |
| pend | output | NSRC | Pending flags |
| ack | output | 1 | Service-routine fetch acknowledge |
| ack_id | output | IDW | Source being acknowledged |

## Verification
The hardest situation to reach is a new detection on the same edge that clears the flag, which only the three-edge pulse produces. The bench holds `fetch_bnd` high so that the first service starts immediately. The third sample of the pulse then lands exactly on the clearing edge, and the bench counts two acknowledges for that one pulse. Priority ordering is reached by queuing several pulses while `fetch_bnd` is low and then opening the boundary, so that all candidates compete at one acceptance.

// File: rtl/irq_vector_pkg.sv
// Shared types for the interrupt vectoring unit.
package irq_vector_pkg;
    // Response sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_VEC  = 2'd1,
        SQ_CAP  = 2'd2,
        SQ_FET  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/irq_sync.sv
// Two-stage synchronizer for the active-low request pins.
// Output is active-high. Assumes the pins idle high.
module irq_sync #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pin_n,
    output logic [NSRC-1:0] req
);
    logic [NSRC-1:0] st1_q;
    logic [NSRC-1:0] st2_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_sync
        // Shift the pin through two flops, reset to the idle level
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1_q[i] <= 1'b1;
                st2_q[i] <= 1'b1;
            end else begin
                st1_q[i] <= pin_n[i];
                st2_q[i] <= st1_q[i];
            end
        end
        assign req[i] = ~st2_q[i];
    end
endmodule

// File: rtl/irq_detect.sv
// Level detector with a one-sample re-arm gap, plus the pending flags.
// A detection sets the flag. A clear request drops the flag unless a
// detection happens on the same edge.
module irq_detect #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] hold_q;
    logic [NSRC-1:0] pend_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_det
        logic hit;
        assign hit = req[i] & ~hold_q[i];

        // Track the ignored sample and update the pending flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                hold_q[i] <= hit;
                if (hit) begin
                    pend_q[i] <= 1'b1;
                end else if (clr[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irq_pick.sv
// Fixed-priority selector: the lowest-numbered candidate wins.
module irq_pick #(
    parameter int NSRC = 4,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] cand,
    output logic            any,
    output logic [IDW-1:0]  win
);
    // Scan from the highest to the lowest index so that the lowest set bit remains
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                win = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_seq.sv
// Response sequencer. It accepts a winner at a fetch boundary, reads the
// vector, captures it, then fetches the service routine.
// Assumes the memory returns data on the cycle after the read strobe.
module irq_seq
    import irq_vector_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h40,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gie,
    input  logic              fetch_bnd,
    input  logic              any,
    input  logic [IDW-1:0]    win,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              ack,
    output logic [IDW-1:0]    ack_id,
    output logic [NSRC-1:0]   clr
);
    seq_state_t        state_q;
    logic [IDW-1:0]    id_q;
    logic [ADDR_W-1:0] vec_q;

    // Advance the sequence and hold the winner and the vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            id_q    <= '0;
            vec_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (fetch_bnd && gie && any) begin
                        id_q    <= win;
                        state_q <= SQ_VEC;
                    end
                end
                SQ_VEC: state_q <= SQ_CAP;
                SQ_CAP: begin
                    vec_q   <= mem_rdata[ADDR_W-1:0];
                    state_q <= SQ_FET;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive the address, strobe and acknowledge for the current state
    always_comb begin
        mem_addr = '0;
        mem_rd   = 1'b0;
        ack      = 1'b0;
        case (state_q)
            SQ_VEC: begin
                mem_addr = VEC_BASE + ADDR_W'(id_q);
                mem_rd   = 1'b1;
            end
            SQ_FET: begin
                mem_addr = vec_q;
                mem_rd   = 1'b1;
                ack      = 1'b1;
            end
            default: ;
        endcase
    end

    assign ack_id = id_q;

    // Clear the winner's flag while its vector is being read
    always_comb begin
        clr = '0;
        if (state_q == SQ_VEC) begin
            clr[id_q] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
// Top level: synchronizer, detector, priority selector and sequencer.
// Every register uses the rising edge of clk as the sampling edge.
module irq_vector_unit #(
    parameter int NSRC = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h40,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_n,
    input  logic              gie,
    input  logic [NSRC-1:0]   int_en,
    input  logic              fetch_bnd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [NSRC-1:0]   pend,
    output logic              ack,
    output logic [IDW-1:0]    ack_id
);
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] clr;
    logic            any;
    logic [IDW-1:0]  win;

    irq_sync #(.NSRC(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(irq_n), .req(req)
    );

    irq_detect #(.NSRC(NSRC)) u_det (
        .clk(clk), .rst_n(rst_n), .req(req), .clr(clr), .pend(pend)
    );

    irq_pick #(.NSRC(NSRC)) u_pick (
        .cand(pend & int_en), .any(any), .win(win)
    );

    irq_seq #(
        .NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .gie(gie), .fetch_bnd(fetch_bnd),
        .any(any), .win(win), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .ack(ack),
        .ack_id(ack_id), .clr(clr)
    );
endmodule

// File: rtl/irq_vector_unit_chk.sv
// Port-level checker for irq_vector_unit, attached with bind.
module irq_vector_unit_chk #(
    parameter int NSRC = 4,
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h40,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gie,
    input logic              fetch_bnd,
    input logic [NSRC-1:0]   int_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              ack
);
    logic              vread;
    logic [ADDR_W-1:0] off;
    assign vread = mem_rd && !ack;
    assign off   = mem_addr - VEC_BASE;

    // R4
    vread_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vread |-> $past(fetch_bnd && gie));

    // R8
    vread_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vread |=> !mem_rd);

    // R6
    vread_enabled_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vread |-> (off < ADDR_W'(NSRC)) && $past(int_en[off[IDW-1:0]]));

    // R9
    ack_with_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> mem_rd);

    // R9
    ack_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(mem_rd, 2) && !$past(mem_rd, 1));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .gie(gie), .fetch_bnd(fetch_bnd),
    .int_en(int_en), .mem_addr(mem_addr), .mem_rd(mem_rd), .ack(ack)
);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
    localparam int NSRC = 4;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] BASE = 24'h40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   irq_n = '1;
    logic              gie = 1'b1;
    logic [NSRC-1:0]   int_en = '1;
    logic              fetch_bnd = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd;
    logic [NSRC-1:0]   pend;
    logic              ack;
    logic [1:0]        ack_id;

    int n_chk = 0;
    int n_fail = 0;
    int acks [NSRC];
    int vreads = 0;
    int ack_log [16];
    int ack_n = 0;

    always #10 clk = ~clk;

    irq_vector_unit #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .gie(gie), .int_en(int_en),
        .fetch_bnd(fetch_bnd), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .pend(pend), .ack(ack), .ack_id(ack_id)
    );

    function automatic logic [DATA_W-1:0] vec_of(input logic [ADDR_W-1:0] a);
        return 32'h0010_0000 + (DATA_W'(a) << 4);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Vector memory model: data is returned the cycle after a vector read
    always @(posedge clk) mem_rdata <= (mem_rd && !ack) ? vec_of(mem_addr) : '0;

    // Monitor reads and acknowledges between clock edges
    always @(negedge clk) begin
        if (rst_n && mem_rd && !ack) begin
            vreads++;
            check(mem_addr >= BASE && mem_addr < BASE + NSRC, "R8 vector address range",
                  mem_addr, BASE);
        end
        if (rst_n && ack) begin
            acks[ack_id]++;
            if (ack_n < 16) ack_log[ack_n] = ack_id;
            ack_n++;
            // R9 fetch address is the returned vector
            check(mem_addr == vec_of(BASE + ADDR_W'(ack_id)) && mem_rd, "R9 fetch address",
                  mem_addr, vec_of(BASE + ADDR_W'(ack_id)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NSRC; i++) acks[i] = 0;
        vreads = 0;
        ack_n = 0;
    endtask

    // Low pulse on the pins in msk covering exactly 'edges' rising edges
    task automatic pulse(input logic [NSRC-1:0] msk, input int edges);
        @(negedge clk);
        irq_n = ~msk;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        irq_n = '1;
    endtask

    // Table: source, pulse length in edges, expected services (R3)
    typedef struct packed { logic [7:0] src; logic [7:0] edges; logic [7:0] exp; } vec_t;
    localparam vec_t TBL [6] = '{
        '{8'd0, 8'd1, 8'd1}, '{8'd1, 8'd2, 8'd1}, '{8'd2, 8'd3, 8'd2},
        '{8'd3, 8'd2, 8'd1}, '{8'd0, 8'd3, 8'd2}, '{8'd3, 8'd1, 8'd1}
    };

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_counts();
        tick(3);
        // R1 reset state
        check(pend == 0 && !mem_rd && !ack, "R1 in reset", {pend, mem_rd, ack}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        check(pend == 0 && !mem_rd && !ack, "R1 after reset", {pend, mem_rd, ack}, 0);

        // R2 latency, with fetch_bnd low so nothing is serviced
        @(negedge clk);
        irq_n[0] = 1'b0;
        tick(1);
        check(pend[0] == 0, "R2 edge 1", pend[0], 0);
        tick(1);
        check(pend[0] == 0, "R2 edge 2", pend[0], 0);
        tick(1);
        check(pend[0] == 1, "R2 edge 3", pend[0], 1);
        irq_n = '1;
        // R4 no read without a fetch boundary
        tick(10);
        check(vreads == 0 && pend[0] == 1, "R4 held pending", vreads, 0);
        fetch_bnd = 1'b1;
        tick(1);
        fetch_bnd = 1'b0;
        check(mem_rd && !ack && mem_addr == BASE, "R8 vector read", mem_addr, BASE);
        check(pend[0] == 1, "R8 flag before clear edge", pend[0], 1);
        tick(1);
        check(pend[0] == 0 && !mem_rd, "R8 flag cleared", pend[0], 0);
        tick(1);
        check(ack && ack_id == 0 && mem_addr == vec_of(BASE), "R9 fetch", mem_addr, vec_of(BASE));
        tick(1);
        check(!ack && !mem_rd, "R9 one cycle", ack, 0);

        // R3 table of pulse lengths with fetch_bnd held high
        fetch_bnd = 1'b1;
        for (int k = 0; k < 6; k++) begin
            clear_counts();
            pulse(NSRC'(1) << TBL[k].src, int'(TBL[k].edges));
            tick(24);
            check(acks[TBL[k].src] == int'(TBL[k].exp) && pend == 0, "R3 services per pulse",
                  acks[TBL[k].src], TBL[k].exp);
        end

        // R5 global enable off: flags set, no read
        clear_counts();
        gie = 1'b0;
        pulse(4'b0100, 1);
        tick(10);
        check(pend[2] == 1 && vreads == 0, "R5 suppressed", {pend, 8'(vreads)}, 12'h400);
        gie = 1'b1;
        tick(12);
        check(pend == 0 && acks[2] == 1, "R5 resumed", acks[2], 1);

        // R6 masked source stays pending
        clear_counts();
        int_en = 4'b1101;
        pulse(4'b1010, 1);
        tick(20);
        check(acks[3] == 1 && acks[1] == 0 && pend[1] == 1, "R6 masked", {acks[1], acks[3]}, 1);
        int_en = '1;
        tick(12);
        check(acks[1] == 1 && pend == 0, "R6 unmasked", acks[1], 1);

        // R7 priority among queued requests
        clear_counts();
        fetch_bnd = 1'b0;
        pulse(4'b1101, 1);
        tick(5);
        check(pend == 4'b1101, "R7 all queued", pend, 4'b1101);
        fetch_bnd = 1'b1;
        tick(30);
        check(ack_n == 3, "R7 service count", ack_n, 3);
        check(ack_log[0] == 0 && ack_log[1] == 2 && ack_log[2] == 3, "R7 order",
              {ack_log[0][3:0], ack_log[1][3:0], ack_log[2][3:0]}, 12'h023);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule